// File: doc/BRIEF.md
# Prescaled Up-Timer with Byte and Word Wrap Interrupts

This block is a free-running up-counter with a selectable count source and a power-of-two prescaler. The count source is one of three choices: halted, the system clock divided by a fixed ratio, or rising edges on an external pin. A pin edge only counts after it has passed through a two-stage synchronizer and an edge detector. Each source pulse goes through the prescaler, which passes on one tick per 1, 2, 4 or 8 pulses. Every tick that leaves the prescaler advances the count by one.

Two wrap events are tracked, each with its own sticky flag. The first is the low byte of the count rolling over to zero. The second is the whole count rolling over to zero. Each flag stays set until its own clear strobe removes it. Each flag also has its own interrupt enable, and the enabled flags are merged into one interrupt request.

With the default parameters (16-bit count, 8-bit low field, divide-by-6 source), a 6 MHz clock produces a full-word wrap every 65,536 µs at prescale 1. Prescale 2, 4 and 8 give twice, four times and eight times that period.

Top module: `dual_ovf_timer`

## Requirements
- R1: During and right after synchronous reset, the count is 0, both flags are 0 and the interrupt request is 0.
- R2: With clk_mode 2'b00 or 2'b11, the count does not change, whatever the external pin does.
- R3: With clk_mode 2'b01 and prescale 1, the count rises by one every DIV_N clock cycles. The first increment comes on the DIV_N-th rising edge after reset is released.
- R4: pre_sel value p divides the source by 2^p: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R5: With clk_mode 2'b10, each rising edge of ext_pin adds exactly one to the count (at prescale 1), after a two-flop synchronizer. A pin held high adds nothing more.
- R6: flag_byte sets on the clock edge where the low LOW_W bits of the count go from all ones to zero. It stays set until a cycle in which clr_byte is high.
- R7: flag_word sets on the clock edge where the count goes from all ones to zero. It stays set until a cycle in which clr_word is high.
- R8: If a clear strobe and a new wrap of the same flag fall on the same cycle, that flag stays set.
- R9: irq = (flag_byte AND ien_byte) OR (flag_word AND ien_word). The two enables act independently.
- R10: A change of pre_sel zeroes the prescale phase. The next tick then comes only after a full period of the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_pin | input | 1 | External count input, asynchronous |
| clk_mode | input | 2 | Count source: 00 halt, 01 clock/DIV_N, 10 pin edges, 11 halt |
| pre_sel | input | 2 | Prescale exponent, ratio 2^pre_sel |
| ien_byte | input | 1 | Interrupt enable for the byte wrap flag |
| ien_word | input | 1 | Interrupt enable for the word wrap flag |
| clr_byte | input | 1 | Clear strobe for flag_byte |
| clr_word | input | 1 | Clear strobe for flag_word |
| count | output | CNT_W | Current count value |
| flag_byte | output | 1 | Sticky low-field wrap flag |
| flag_word | output | 1 | Sticky full-count wrap flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the timer with CNT_W=10, LOW_W=4 and DIV_N=3. A full-word wrap then takes 3,072 cycles at prescale 1, instead of nearly 400,000 at the default sizes. With these sizes the bench can count an exact cycle for both wrap flags, for the set-over-clear collision and for every prescale ratio within a short run. The divide counter, the low-field boundary and the all-ones compare are the same logic as at the default sizes, only narrower.

// File: rtl/pstmr_pkg.sv
package pstmr_pkg;

    localparam int PRE_W     = 2;
    localparam int PHASE_W   = (1 << PRE_W) - 1;

    typedef enum logic [1:0] {
        SRC_HALT     = 2'b00,
        SRC_SYSDIV   = 2'b01,
        SRC_PIN      = 2'b10,
        SRC_HALT_ALT = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic word_wrap;
        logic byte_wrap;
    } wrap_t;

    function automatic logic [PHASE_W-1:0] phase_limit(input logic [PRE_W-1:0] p);
        logic [PHASE_W:0] one_hot;
        one_hot = (PHASE_W+1)'(1) << p;
        return PHASE_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/pstmr_tick_src.sv
module pstmr_tick_src
    import pstmr_pkg::*;
#(
    parameter int DIV_N = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  src_sel_e src,
    input  logic     ext_pin,
    output logic     raw_tick
);
    localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic             div_hit;
    logic [2:0]       pin_sh;
    logic             pin_rise;

    assign div_hit = (div_cnt == DIV_W'(DIV_N - 1));

    always_ff @(posedge clk) begin
        if (rst || src != SRC_SYSDIV) begin
            div_cnt <= '0;
        end else if (div_hit) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_sh <= '0;
        end else begin
            pin_sh <= {pin_sh[1:0], ext_pin};
        end
    end

    assign pin_rise = pin_sh[1] & ~pin_sh[2];

    always_comb begin
        unique case (src)
            SRC_SYSDIV: raw_tick = div_hit;
            SRC_PIN:    raw_tick = pin_rise;
            default:    raw_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pstmr_prescale.sv
module pstmr_prescale
    import pstmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic             raw_tick,
    output logic             tick
);
    logic [PRE_W-1:0]   pre_q;
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] limit;
    logic               pre_chg;
    logic               at_limit;

    assign limit    = phase_limit(pre_sel);
    assign pre_chg  = (pre_sel != pre_q);
    assign at_limit = (phase == limit);
    assign tick     = raw_tick & at_limit & ~pre_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            phase <= '0;
        end else begin
            pre_q <= pre_sel;
            if (pre_chg) begin
                phase <= '0;
            end else if (raw_tick) begin
                phase <= at_limit ? '0 : phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pstmr_count.sv
module pstmr_count
    import pstmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output wrap_t            wrap
);
    always_comb begin
        wrap.byte_wrap = tick & (&count[LOW_W-1:0]);
        wrap.word_wrap = tick & (&count);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pstmr_flags.sv
module pstmr_flags
    import pstmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wrap_t set_ev,
    input  wrap_t clr_ev,
    input  wrap_t ien,
    output wrap_t flags,
    output logic  irq
);
    localparam int NFLAG = $bits(wrap_t);

    logic [NFLAG-1:0] set_v, clr_v, flag_v, ien_v;

    assign set_v = set_ev;
    assign clr_v = clr_ev;
    assign ien_v = ien;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_v[g] <= 1'b0;
            end else begin
                flag_v[g] <= set_v[g] | (flag_v[g] & ~clr_v[g]);
            end
        end
    end

    assign flags = flag_v;
    assign irq   = |(flag_v & ien_v);

endmodule

// File: rtl/dual_ovf_timer.sv
module dual_ovf_timer
    import pstmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8,
    parameter int DIV_N = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic [1:0]       clk_mode,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic             ien_byte,
    input  logic             ien_word,
    input  logic             clr_byte,
    input  logic             clr_word,
    output logic [CNT_W-1:0] count,
    output logic             flag_byte,
    output logic             flag_word,
    output logic             irq
);
    src_sel_e src;
    logic     raw_tick;
    logic     tick;
    wrap_t    wrap;
    wrap_t    clr_ev;
    wrap_t    ien;
    wrap_t    flags;

    assign src = src_sel_e'(clk_mode);

    assign clr_ev.byte_wrap = clr_byte;
    assign clr_ev.word_wrap = clr_word;
    assign ien.byte_wrap    = ien_byte;
    assign ien.word_wrap    = ien_word;

    pstmr_tick_src #(.DIV_N(DIV_N)) u_src (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .ext_pin  (ext_pin),
        .raw_tick (raw_tick)
    );

    pstmr_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .pre_sel  (pre_sel),
        .raw_tick (raw_tick),
        .tick     (tick)
    );

    pstmr_count #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (count),
        .wrap  (wrap)
    );

    pstmr_flags u_flg (
        .clk    (clk),
        .rst    (rst),
        .set_ev (wrap),
        .clr_ev (clr_ev),
        .ien    (ien),
        .flags  (flags),
        .irq    (irq)
    );

    assign flag_byte = flags.byte_wrap;
    assign flag_word = flags.word_wrap;

endmodule

// File: rtl/dual_ovf_timer_chk.sv
module dual_ovf_timer_chk #(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       clk_mode,
    input logic             clr_byte,
    input logic             clr_word,
    input logic [CNT_W-1:0] count,
    input logic             flag_byte,
    input logic             flag_word,
    input logic             irq
);
    // R2: a halted source leaves the count unchanged
    p_halt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (clk_mode == 2'b00 || clk_mode == 2'b11) |=> $stable(count));

    // R3: the count never moves by more than one per cycle
    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R6: the byte flag rises only out of an all-ones low field
    p_byte_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_byte) |-> (&$past(count[LOW_W-1:0])) && (count[LOW_W-1:0] == '0));

    // R7: the word flag rises only out of an all-ones count
    p_word_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_word) |-> (&$past(count)) && (count == '0));

    // R7: without a clear the word flag holds
    p_word_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_word && !clr_word) |=> flag_word);

    // R6: without a clear the byte flag holds
    p_byte_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_byte && !clr_byte) |=> flag_byte);

    // R9: no request without a pending flag
    p_no_flag_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (!flag_byte && !flag_word) |-> !irq);

endmodule

bind dual_ovf_timer dual_ovf_timer_chk #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_mode  (clk_mode),
    .clr_byte  (clr_byte),
    .clr_word  (clr_word),
    .count     (count),
    .flag_byte (flag_byte),
    .flag_word (flag_word),
    .irq       (irq)
);

// File: tb/dual_ovf_timer_tb.sv
`timescale 1ns/1ps
module dual_ovf_timer_tb;
    localparam int CNT_W = 10;
    localparam int LOW_W = 4;
    localparam int DIV_N = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ext_pin = 1'b0;
    logic [1:0]       clk_mode = 2'b00;
    logic [1:0]       pre_sel = 2'b00;
    logic             ien_byte = 1'b0;
    logic             ien_word = 1'b0;
    logic             clr_byte = 1'b0;
    logic             clr_word = 1'b0;
    logic [CNT_W-1:0] count;
    logic             flag_byte, flag_word, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_ovf_timer #(.CNT_W(CNT_W), .LOW_W(LOW_W), .DIV_N(DIV_N)) u_dut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .clk_mode(clk_mode),
        .pre_sel(pre_sel), .ien_byte(ien_byte), .ien_word(ien_word),
        .clr_byte(clr_byte), .clr_word(clr_word), .count(count),
        .flag_byte(flag_byte), .flag_word(flag_word), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int m);
        repeat (m) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [1:0] mode, input logic [1:0] pre);
        @(negedge clk);
        rst = 1'b1; clk_mode = mode; pre_sel = pre;
        ien_byte = 0; ien_word = 0; clr_byte = 0; clr_word = 0; ext_pin = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 count in reset", count, 0);
        chk("R1 flags in reset", {flag_byte, flag_word, irq}, 0);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        start(2'b01, 2'b00);
        run(1);
        chk("R1 count after release", count, 0);
        chk("R1 irq after release", irq, 0);
    endtask

    task automatic t_halt(input logic [1:0] mode);
        start(mode, 2'b00);
        for (int i = 0; i < 6; i++) begin
            ext_pin = 1; run(3); ext_pin = 0; run(3);
        end
        run(40);
        chk("R2 halted count", count, 0);
    endtask

    task automatic t_ratio(input logic [1:0] pre);
        start(2'b01, pre);
        run(DIV_N - 1);
        chk("R3 before first tick", count, 0);
        run(48 - (DIV_N - 1));
        chk("R4 prescale count", count, 48 / (DIV_N * (1 << pre)));
    endtask

    task automatic t_pin();
        start(2'b10, 2'b00);
        for (int i = 0; i < 5; i++) begin
            ext_pin = 1; run(3); ext_pin = 0; run(3);
        end
        run(6);
        chk("R5 pin edges counted", count, 5);
        ext_pin = 1; run(30);
        chk("R5 held level counts once", count, 6);
    endtask

    task automatic t_byte();
        start(2'b01, 2'b00);
        ien_word = 1;
        run(DIV_N * 16 - 1);
        chk("R6 byte flag before wrap", flag_byte, 0);
        run(1);
        chk("R6 byte flag at wrap", flag_byte, 1);
        chk("R6 count at wrap", count, 16);
        chk("R9 byte flag not enabled", irq, 0);
        ien_byte = 1; #1;
        chk("R9 byte flag enabled", irq, 1);
        run(10);
        chk("R6 byte flag sticky", flag_byte, 1);
        clr_byte = 1; run(1); clr_byte = 0;
        chk("R6 byte flag cleared", flag_byte, 0);
        chk("R9 irq drops", irq, 0);
        // edge 59 now; next low-field wrap on edge 96
        run(96 - 59 - 1);
        clr_byte = 1; run(1); clr_byte = 0;
        chk("R8 set wins over clear", flag_byte, 1);
        clr_byte = 1; run(1); clr_byte = 0;
        chk("R8 clear afterwards", flag_byte, 0);
    endtask

    task automatic t_word();
        start(2'b01, 2'b00);
        ien_byte = 0; ien_word = 1;
        run(DIV_N * (1 << CNT_W) - 1);
        chk("R7 count before wrap", count, (1 << CNT_W) - 1);
        chk("R7 word flag before wrap", flag_word, 0);
        run(1);
        chk("R7 word flag at wrap", flag_word, 1);
        chk("R7 count wraps to zero", count, 0);
        chk("R9 word flag enabled", irq, 1);
        ien_word = 0; #1;
        chk("R9 word enable off", irq, 0);
        run(20);
        chk("R7 word flag sticky", flag_word, 1);
        clr_word = 1; run(1); clr_word = 0;
        chk("R7 word flag cleared", flag_word, 0);
    endtask

    task automatic t_prechg();
        start(2'b01, 2'b11);
        run(30);
        chk("R10 count before change", count, 1);
        pre_sel = 2'b01;
        run(5);
        chk("R10 no early tick", count, 1);
        run(1);
        chk("R10 tick after full new period", count, 2);
    endtask

    initial begin
        t_reset();
        t_halt(2'b00);
        t_halt(2'b11);
        for (int p = 0; p < 4; p++) t_ratio(2'(p));
        t_pin();
        t_byte();
        t_word();
        t_prechg();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule